// File: doc/BRIEF.md
# ICOUNT Fetch Thread Selector

This block decides, every cycle, which hardware thread of a simultaneous multithreaded front end gets the fetch slot. For each thread it tracks how many instructions sit between fetch and issue. The count rises by the number of instructions fetched for that thread and falls by the number issued or squashed. The thread with the smallest live count wins. This keeps any one thread from crowding the shared issue queue and steers fetch toward threads that drain quickly.

A thread whose instruction buffer reports full cannot be chosen. Software can bias the choice by adding a per-thread offset to that thread's count before the comparison. When several eligible threads share the smallest effective count, the one nearest after the previously chosen thread, in rotating order, wins. The selection is combinational from the registered counts and the current-cycle inputs. The counts and the rotation pointer update on the rising clock edge.

Top module: `icount_fetch_sel`

## Requirements
- R1: After reset every count is zero and the rotation pointer sits on the highest thread index, so with no buffer full and no bias, thread 0 is selected with valid high.
- R2: At each clock edge a thread's count becomes its old value plus its fetch amount minus its issue/squash amount, both applied in the same cycle.
- R3: A count saturates at 2^CNT_W-1 and never wraps upward.
- R4: A count never goes below zero. A decrement larger than the count plus the increment leaves zero.
- R5: Among eligible threads, the one with the smallest effective count (count plus active bias) is selected.
- R6: Among eligible threads tied at the smallest effective count, the winner is the first one met when scanning upward from the last selected thread plus one, wrapping from the highest index to 0.
- R7: A thread whose buffer-full bit (bit t of `buf_full_i`) is high is never selected.
- R8: When every buffer-full bit is high, `sel_valid_o` is low.
- R9: When bit t of `bias_en_i` is high, the field `bias_val_i[t*CNT_W +: CNT_W]` is added to thread t's count before the comparison. When the bit is low, no offset is added.
- R10: The rotation pointer takes the selected thread on cycles where `sel_valid_o` is high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_amt_i | input | NUM_THR*STEP_W | Per-thread count of instructions accepted into fetch this cycle (field t at t*STEP_W) |
| drain_amt_i | input | NUM_THR*STEP_W | Per-thread count of instructions issued or squashed this cycle |
| buf_full_i | input | NUM_THR | Per-thread buffer-full flags |
| bias_en_i | input | NUM_THR | Per-thread enable of the priority offset |
| bias_val_i | input | NUM_THR*CNT_W | Per-thread priority offset |
| sel_valid_o | output | 1 | A thread was selected this cycle |
| sel_tid_o | output | TID_W | Selected thread index |

## Verification
A count update and a selection happen in the same cycle. The selection uses the count from before the edge, while the fetch and drain amounts applied in that cycle shape the next choice. The bench drives simultaneous fetch and drain amounts on all threads during long random stretches, with scattered buffer-full flags and biases. It compares every cycle's selection against an arithmetic model that keeps its own counts and pointer. Directed phases push the counts into saturation and into the floor, rotate ties, sweep all buffer-full patterns and apply offsets, so count clamping and tie rotation are judged in the cycle they interact.

// File: rtl/icf_pkg.sv
package icf_pkg;
   function automatic int tid_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/icf_counter.sv
module icf_counter #(
   parameter int CNT_W  = 6,
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STEP_W-1:0] inc_i,
   input  logic [STEP_W-1:0] dec_i,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam int SUM_W = CNT_W + 2;
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   if (STEP_W > CNT_W) begin : g_bad_step
      $error("STEP_W must not exceed CNT_W");
   end

   logic [CNT_W-1:0]        cnt_q, cnt_d;
   logic signed [SUM_W-1:0] sum;

   always_comb begin
      sum = $signed(SUM_W'(cnt_q)) + $signed(SUM_W'(inc_i)) - $signed(SUM_W'(dec_i));
      if (sum < 0)
         cnt_d = '0;
      else if (sum > $signed(SUM_W'(TOP)))
         cnt_d = TOP;
      else
         cnt_d = sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   // R3
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == TOP && inc_i >= dec_i) |=> cnt_q == TOP);
   // R4
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && dec_i >= inc_i) |=> cnt_q == '0);
endmodule

// File: rtl/icf_picker.sv
module icf_picker #(
   parameter int  NUM_THR  = 4,
   parameter int  CNT_W    = 6,
   parameter bit  USE_BIAS = 1'b1,
   parameter int  TID_W    = icf_pkg::tid_width(NUM_THR)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_THR*CNT_W-1:0] cnt_i,
   input  logic [NUM_THR-1:0]       full_i,
   input  logic [NUM_THR-1:0]       bias_en_i,
   input  logic [NUM_THR*CNT_W-1:0] bias_val_i,
   input  logic [TID_W-1:0]         last_i,
   output logic                     valid_o,
   output logic [TID_W-1:0]         tid_o
);
   localparam int KEY_W = CNT_W + 1;

   logic [KEY_W-1:0] key [NUM_THR];

   for (genvar t = 0; t < NUM_THR; t++) begin : g_key
      if (USE_BIAS) begin : g_bias
         assign key[t] = KEY_W'(cnt_i[t*CNT_W +: CNT_W])
                       + (bias_en_i[t] ? KEY_W'(bias_val_i[t*CNT_W +: CNT_W]) : '0);
      end else begin : g_plain
         assign key[t] = KEY_W'(cnt_i[t*CNT_W +: CNT_W]);
      end
   end

   always_comb begin
      logic [KEY_W-1:0] best_key;
      logic             found;
      logic [TID_W-1:0] best;
      int unsigned      idx;
      best_key = '1;
      found    = 1'b0;
      best     = '0;
      for (int k = 0; k < NUM_THR; k++) begin
         idx = (int'(last_i) + 1 + k) % NUM_THR;
         if (!full_i[idx] && (!found || key[idx] < best_key)) begin
            found    = 1'b1;
            best_key = key[idx];
            best     = TID_W'(idx);
         end
      end
      valid_o = found;
      tid_o   = best;
   end

   // R7
   no_full_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !full_i[tid_o]);

   for (genvar j = 0; j < NUM_THR; j++) begin : g_min_chk
      // R5
      min_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_o && !full_i[j]) |-> key[j] >= key[tid_o]);
   end
endmodule

// File: rtl/icount_fetch_sel.sv
module icount_fetch_sel #(
   parameter int NUM_THR  = 4,
   parameter int CNT_W    = 6,
   parameter int STEP_W   = 3,
   parameter bit USE_BIAS = 1'b1,
   parameter int TID_W    = icf_pkg::tid_width(NUM_THR)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_THR*STEP_W-1:0] fetch_amt_i,
   input  logic [NUM_THR*STEP_W-1:0] drain_amt_i,
   input  logic [NUM_THR-1:0]        buf_full_i,
   input  logic [NUM_THR-1:0]        bias_en_i,
   input  logic [NUM_THR*CNT_W-1:0]  bias_val_i,
   output logic                      sel_valid_o,
   output logic [TID_W-1:0]          sel_tid_o
);
   if (NUM_THR < 2) begin : g_bad_thr
      $error("NUM_THR must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   logic [NUM_THR*CNT_W-1:0] cnt_flat;
   logic [TID_W-1:0]         last_q;

   for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      icf_counter #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc_i (fetch_amt_i[t*STEP_W +: STEP_W]),
         .dec_i (drain_amt_i[t*STEP_W +: STEP_W]),
         .cnt_o (cnt_flat[t*CNT_W +: CNT_W])
      );
   end

   icf_picker #(.NUM_THR(NUM_THR), .CNT_W(CNT_W), .USE_BIAS(USE_BIAS), .TID_W(TID_W)) u_pick (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_i      (cnt_flat),
      .full_i     (buf_full_i),
      .bias_en_i  (bias_en_i),
      .bias_val_i (bias_val_i),
      .last_i     (last_q),
      .valid_o    (sel_valid_o),
      .tid_o      (sel_tid_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           last_q <= TID_W'(NUM_THR - 1);
      else if (sel_valid_o) last_q <= sel_tid_o;
   end

   // R8
   all_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&buf_full_i) |-> !sel_valid_o);
   // R10
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid_o |=> $stable(last_q));
   // R10
   ptr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid_o |=> last_q == $past(sel_tid_o));
endmodule

// File: tb/sim_icount_fetch_sel.sv
module sim_icount_fetch_sel;
   localparam int N  = 4;
   localparam int CW = 6;
   localparam int SW = 3;
   localparam int TW = 2;
   localparam int TOP = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N*SW-1:0] fetch_v = '0, drain_v = '0;
   logic [N-1:0]    full_v = '0, ben_v = '0;
   logic [N*CW-1:0] bval_v = '0;
   logic            valid;
   logic [TW-1:0]   tid;

   int total = 0, bad = 0;
   int mcnt [N];
   int mptr = N - 1;
   bit done = 0;

   always #5 clk = ~clk;

   icount_fetch_sel #(.NUM_THR(N), .CNT_W(CW), .STEP_W(SW)) u0 (
      .clk(clk), .rst_n(rst_n), .fetch_amt_i(fetch_v), .drain_amt_i(drain_v),
      .buf_full_i(full_v), .bias_en_i(ben_v), .bias_val_i(bval_v),
      .sel_valid_o(valid), .sel_tid_o(tid));

   task automatic expect_sel(output bit ev, output int et);
      int bk = 0;
      ev = 0; et = 0;
      for (int k = 0; k < N; k++) begin
         int i = (mptr + 1 + k) % N;
         int key = mcnt[i] + (ben_v[i] ? int'(bval_v[i*CW +: CW]) : 0);
         if (!full_v[i] && (!ev || key < bk)) begin
            ev = 1; bk = key; et = i;
         end
      end
   endtask

   // inputs already set after a falling edge; check, then advance one clock
   task automatic step(input string tag);
      bit ev; int et;
      #1;
      expect_sel(ev, et);
      total++;
      if (valid !== ev || (ev && int'(tid) != et)) begin
         bad++;
         $display("FAIL %s: valid=%0d tid=%0d expected valid=%0d tid=%0d",
                  tag, valid, tid, ev, et);
      end
      @(posedge clk);
      for (int t = 0; t < N; t++) begin
         int s = mcnt[t] + int'(fetch_v[t*SW +: SW]) - int'(drain_v[t*SW +: SW]);
         mcnt[t] = (s < 0) ? 0 : (s > TOP) ? TOP : s;
      end
      if (ev) mptr = et;
      @(negedge clk);
   endtask

   task automatic set_all(input int f, input int d);
      for (int t = 0; t < N; t++) begin
         fetch_v[t*SW +: SW] = SW'(f);
         drain_v[t*SW +: SW] = SW'(d);
      end
   endtask

   initial begin
      for (int t = 0; t < N; t++) mcnt[t] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      step("R1");
      step("R1");
      // R2 simultaneous fetch and drain
      fetch_v = {3'd6, 3'd2, 3'd4, 3'd5};
      drain_v = {3'd3, 3'd0, 3'd0, 3'd2};
      step("R2");
      set_all(0, 0);
      step("R2");
      step("R2");
      // R3 saturation
      set_all(7, 1);
      for (int c = 0; c < 14; c++) step("R3");
      fetch_v[SW +: SW] = 3'd0; drain_v[SW +: SW] = 3'd2;
      step("R3");
      set_all(0, 0);
      for (int c = 0; c < 4; c++) step("R3");
      // R4 floor
      set_all(1, 7);
      for (int c = 0; c < 14; c++) step("R4");
      set_all(0, 0);
      fetch_v[2*SW +: SW] = 3'd1;
      step("R4");
      set_all(0, 0);
      step("R4");
      // R6 tie rotation at equal counts
      fetch_v[2*SW +: SW] = 3'd0; drain_v[2*SW +: SW] = 3'd1;
      step("R6");
      set_all(0, 0);
      for (int c = 0; c < 8; c++) step("R6");
      // R7/R8/R10 sweep of every buffer-full pattern
      for (int p = 0; p < (1 << N); p++) begin
         full_v = N'(p);
         step((p == (1 << N) - 1) ? "R8" : "R7");
         step("R10");
      end
      full_v = '0;
      step("R10");
      // R9 bias offsets
      ben_v = 4'b0111;
      bval_v = {6'd0, 6'd2, 6'd1, 6'd3};
      step("R9");
      step("R9");
      ben_v = 4'b1111;
      bval_v = {6'd5, 6'd2, 6'd1, 6'd3};
      step("R9");
      bval_v[1*CW +: CW] = 6'd63;
      step("R9");
      ben_v = '0;
      step("R9");
      // R5 long mixed stretch
      for (int c = 0; c < 4000; c++) begin
         for (int t = 0; t < N; t++) begin
            fetch_v[t*SW +: SW] = SW'($urandom_range(0, 7));
            drain_v[t*SW +: SW] = SW'($urandom_range(0, 7));
            full_v[t] = ($urandom_range(0, 5) == 0);
            ben_v[t]  = ($urandom_range(0, 3) == 0);
            bval_v[t*CW +: CW] = CW'($urandom_range(0, 12));
         end
         step("R5");
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule